// File: doc/BRIEF.md
# Error Aggregator with Capture Logging

This block gathers error reports from several bus-initiator sources. In any clock cycle a source may raise a one-cycle error strobe together with the system address of the failing access and a multibit error code. When several sources report at once, the lowest-numbered source is served. A sticky flag records that the other reports were dropped. A source built without a code field has its code forced to the uncorrectable value 0x40.

Each served error is classed as high or low priority from its code. High and low errors each have their own sticky capture bank, which holds address and code. A bank keeps the first error it receives until software clears it, so a low-priority report can never displace a logged high-priority one. The program counter present at the first high-priority error is frozen in a separate snapshot. That snapshot has its own lock. One cycle after an error is served, a one-cycle pulse leaves on the high or the low output toward the downstream signalling logic.

Software reads the capture state on the output ports and clears it through a write-one-to-clear strobe. The strobe has four independent bits.

Top module: `err_aggregator`

## Requirements
- R1: When several sources strobe in the same cycle, the source with the lowest index is served, and only its address and code are logged.
- R2: A cycle with two or more source strobes sets the sticky overflow flag `ovf_o`. The flag stays set until it is cleared by software.
- R3: An error whose code has bit 6 set (mask parameter, default 0x40) is high priority. Every other code is low priority.
- R4: A source whose bit in the code-present parameter is 0 is logged and classed with code 0x40, whatever is on its code input.
- R5: Each priority bank captures the address and code of the first error of its class. It then holds them, with its valid bit set, until that valid bit is cleared. Low-priority errors never alter the high bank.
- R6: The program counter is captured at the first high-priority error and then held with `pc_valid_o` set. It is released only by its own clear bit, independently of the high bank.
- R7: `hi_pulse_o` or `lo_pulse_o` is high for exactly the one cycle after a served error of that class. The two are never high together.
- R8: When `clr_we_i` is high, clear bits 0, 1, 2 and 3 clear, in that order, the high valid bit, the low valid bit, the overflow flag and the PC lock, each independently. An error or overflow arriving in the same cycle wins over its clear.
- R9: Reset clears all valid bits, the overflow flag, the PC lock and both pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_err_i | input | N_SRC | One-cycle error strobes, one per source |
| src_addr_i | input | N_SRC*AW | Packed addresses, source i at bits [i*AW +: AW] |
| src_type_i | input | N_SRC*TW | Packed error codes, source i at bits [i*TW +: TW] |
| pc_i | input | PW | Current program counter of the initiator |
| clr_we_i | input | 1 | Clear write strobe |
| clr_bits_i | input | 4 | Write-one-to-clear bits: 0 high valid, 1 low valid, 2 overflow, 3 PC lock |
| hi_pulse_o | output | 1 | Registered high-priority error pulse |
| lo_pulse_o | output | 1 | Registered low-priority error pulse |
| hi_valid_o | output | 1 | High bank holds an error |
| hi_addr_o | output | AW | Logged high-priority address |
| hi_type_o | output | TW | Logged high-priority code |
| lo_valid_o | output | 1 | Low bank holds an error |
| lo_addr_o | output | AW | Logged low-priority address |
| lo_type_o | output | TW | Logged low-priority code |
| ovf_o | output | 1 | Sticky dropped-error flag |
| pc_valid_o | output | 1 | PC snapshot is locked |
| pc_o | output | PW | Frozen program counter |

## Verification
The bench builds the block with three sources and 8-bit address, code and PC fields. Source 2 is built without a code field. With three sources, all seven strobe combinations can be driven, which covers every arbitration outcome and every overflow case. The 8-bit code lets the bench sweep all 256 codes through the classifier. The code-less source exercises the forced uncorrectable code against codes that would otherwise be classed low. Directed sequences then walk through hold, independent clears and clear-versus-capture collisions.

// File: rtl/err_agg_pkg.sv
`timescale 1ns/1ps
package err_agg_pkg;

    // Bit positions inside the write-one-to-clear word
    localparam int CLR_HI  = 0;
    localparam int CLR_LO  = 1;
    localparam int CLR_OVF = 2;
    localparam int CLR_PC  = 3;
    localparam int CLR_W   = 4;

    localparam int CODE_MAX_W = 64;

    typedef enum logic {
        PRIO_LO = 1'b0,
        PRIO_HI = 1'b1
    } prio_e;

    typedef struct packed {
        logic  hi;
        logic  lo;
        logic  ovf;
        logic  pc;
    } clr_req_t;

    // Class a code against the high-priority mask
    function automatic prio_e code_prio(input logic [CODE_MAX_W-1:0] code,
                                        input logic [CODE_MAX_W-1:0] mask);
        return (|(code & mask)) ? PRIO_HI : PRIO_LO;
    endfunction

    // Decode the clear word into separate requests
    function automatic clr_req_t clr_decode(input logic we, input logic [CLR_W-1:0] bits);
        clr_req_t r;
        r.hi  = we & bits[CLR_HI];
        r.lo  = we & bits[CLR_LO];
        r.ovf = we & bits[CLR_OVF];
        r.pc  = we & bits[CLR_PC];
        return r;
    endfunction

endpackage

// File: rtl/err_type_fill.sv
`timescale 1ns/1ps
module err_type_fill #(
    parameter int                  N_SRC        = 4,
    parameter int                  TW           = 8,
    parameter logic [N_SRC-1:0]    TYPE_PRESENT = '1,
    parameter logic [TW-1:0]       UNCORR_CODE  = TW'('h40)
) (
    input  logic [N_SRC*TW-1:0] raw_type_i,
    output logic [N_SRC*TW-1:0] eff_type_o
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        if (TYPE_PRESENT[i]) begin : g_pass
            assign eff_type_o[i*TW +: TW] = raw_type_i[i*TW +: TW];
        end else begin : g_tie
            assign eff_type_o[i*TW +: TW] = UNCORR_CODE;
        end
    end
endmodule

// File: rtl/err_arb.sv
`timescale 1ns/1ps
module err_arb #(
    parameter int N_SRC = 4,
    parameter int AW    = 32,
    parameter int TW    = 8,
    localparam int IW   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_SRC-1:0]    req_i,
    input  logic [N_SRC*AW-1:0] addr_i,
    input  logic [N_SRC*TW-1:0] type_i,
    output logic                any_o,
    output logic                multi_o,
    output logic [IW-1:0]       win_idx_o,
    output logic [AW-1:0]       win_addr_o,
    output logic [TW-1:0]       win_type_o
);
    logic [IW:0] req_cnt;

    // Descending scan: the lowest requesting index is assigned last and wins
    always_comb begin
        any_o      = 1'b0;
        win_idx_o  = '0;
        win_addr_o = '0;
        win_type_o = '0;
        req_cnt    = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                any_o      = 1'b1;
                win_idx_o  = IW'(i);
                win_addr_o = addr_i[i*AW +: AW];
                win_type_o = type_i[i*TW +: TW];
                req_cnt    = req_cnt + 1'b1;
            end
        end
        multi_o = (req_cnt > 1);
    end

    logic [N_SRC-1:0] below_win;
    always_comb below_win = (N_SRC'(1) << win_idx_o) - N_SRC'(1);

    assert_winner_requests_R1: assert property (@(posedge clk) disable iff (rst)
        any_o |-> req_i[win_idx_o]);
    assert_no_lower_request_R1: assert property (@(posedge clk) disable iff (rst)
        any_o |-> ((req_i & below_win) == '0));
    assert_multi_count_R2: assert property (@(posedge clk) disable iff (rst)
        multi_o == ($countones(req_i) > 1));
endmodule

// File: rtl/err_bank.sv
`timescale 1ns/1ps
module err_bank #(
    parameter int DW = 40
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap_i,
    input  logic          clr_i,
    input  logic [DW-1:0] data_i,
    output logic          valid_o,
    output logic [DW-1:0] data_o
);
    logic take;

    // A bank opens for a new capture when empty or when being cleared now
    always_comb take = cap_i && (!valid_o || clr_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            data_o  <= '0;
        end else begin
            if (take) begin
                valid_o <= 1'b1;
                data_o  <= data_i;
            end else if (clr_i) begin
                valid_o <= 1'b0;
            end
        end
    end

    // Also guards the PC snapshot bank (R6)
    assert_bank_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !clr_i) |=> (valid_o && $stable(data_o)));
    assert_bank_capture_R8: assert property (@(posedge clk) disable iff (rst)
        (cap_i && clr_i) |=> (valid_o && data_o == $past(data_i)));
endmodule

// File: rtl/err_aggregator.sv
`timescale 1ns/1ps
module err_aggregator
    import err_agg_pkg::*;
#(
    parameter int               N_SRC        = 4,
    parameter int               AW           = 32,
    parameter int               TW           = 8,
    parameter int               PW           = 32,
    parameter logic [N_SRC-1:0] TYPE_PRESENT = '1,
    parameter logic [TW-1:0]    UNCORR_CODE  = TW'('h40),
    parameter logic [TW-1:0]    HI_MASK      = TW'('h40)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_SRC-1:0]    src_err_i,
    input  logic [N_SRC*AW-1:0] src_addr_i,
    input  logic [N_SRC*TW-1:0] src_type_i,
    input  logic [PW-1:0]       pc_i,
    input  logic                clr_we_i,
    input  logic [3:0]          clr_bits_i,
    output logic                hi_pulse_o,
    output logic                lo_pulse_o,
    output logic                hi_valid_o,
    output logic [AW-1:0]       hi_addr_o,
    output logic [TW-1:0]       hi_type_o,
    output logic                lo_valid_o,
    output logic [AW-1:0]       lo_addr_o,
    output logic [TW-1:0]       lo_type_o,
    output logic                ovf_o,
    output logic                pc_valid_o,
    output logic [PW-1:0]       pc_o
);
    localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;
    localparam int RW = AW + TW;

    logic [N_SRC*TW-1:0] eff_type;
    logic                any, multi;
    logic [IW-1:0]       win_idx;
    logic [AW-1:0]       win_addr;
    logic [TW-1:0]       win_type;
    prio_e               win_prio;
    clr_req_t            clr;
    logic                cap_hi, cap_lo;

    err_type_fill #(
        .N_SRC(N_SRC), .TW(TW), .TYPE_PRESENT(TYPE_PRESENT), .UNCORR_CODE(UNCORR_CODE)
    ) u_fill (
        .raw_type_i (src_type_i),
        .eff_type_o (eff_type)
    );

    err_arb #(.N_SRC(N_SRC), .AW(AW), .TW(TW)) u_arb (
        .clk        (clk),
        .rst        (rst),
        .req_i      (src_err_i),
        .addr_i     (src_addr_i),
        .type_i     (eff_type),
        .any_o      (any),
        .multi_o    (multi),
        .win_idx_o  (win_idx),
        .win_addr_o (win_addr),
        .win_type_o (win_type)
    );

    always_comb begin
        win_prio = code_prio(CODE_MAX_W'(win_type), CODE_MAX_W'(HI_MASK));
        clr      = clr_decode(clr_we_i, clr_bits_i);
        cap_hi   = any && (win_prio == PRIO_HI);
        cap_lo   = any && (win_prio == PRIO_LO);
    end

    // Capture banks: index 0 high, index 1 low
    logic [1:0]    bank_cap, bank_clr, bank_valid;
    logic [RW-1:0] bank_data [2];

    assign bank_cap = {cap_lo, cap_hi};
    assign bank_clr = {clr.lo, clr.hi};

    for (genvar b = 0; b < 2; b++) begin : g_bank
        err_bank #(.DW(RW)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .cap_i   (bank_cap[b]),
            .clr_i   (bank_clr[b]),
            .data_i  ({win_addr, win_type}),
            .valid_o (bank_valid[b]),
            .data_o  (bank_data[b])
        );
    end

    err_bank #(.DW(PW)) u_pc (
        .clk     (clk),
        .rst     (rst),
        .cap_i   (cap_hi),
        .clr_i   (clr.pc),
        .data_i  (pc_i),
        .valid_o (pc_valid_o),
        .data_o  (pc_o)
    );

    assign hi_valid_o = bank_valid[0];
    assign {hi_addr_o, hi_type_o} = bank_data[0];
    assign lo_valid_o = bank_valid[1];
    assign {lo_addr_o, lo_type_o} = bank_data[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_o      <= 1'b0;
            hi_pulse_o <= 1'b0;
            lo_pulse_o <= 1'b0;
        end else begin
            hi_pulse_o <= cap_hi;
            lo_pulse_o <= cap_lo;
            if (multi)        ovf_o <= 1'b1;
            else if (clr.ovf) ovf_o <= 1'b0;
        end
    end

    assert_pulse_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !(hi_pulse_o && lo_pulse_o));
    assert_pulse_after_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        (|src_err_i) |=> (hi_pulse_o || lo_pulse_o));
    assert_hi_pulse_logged_R5: assert property (@(posedge clk) disable iff (rst)
        hi_pulse_o |-> (hi_valid_o && pc_valid_o));
    assert_overflow_set_R2: assert property (@(posedge clk) disable iff (rst)
        ($countones(src_err_i) > 1) |=> ovf_o);
    assert_overflow_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        (ovf_o && !(clr_we_i && clr_bits_i[CLR_OVF])) |=> ovf_o);
    assert_pc_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (pc_valid_o && !(clr_we_i && clr_bits_i[CLR_PC])) |=> (pc_valid_o && $stable(pc_o)));
    assert_high_code_class_R3: assert property (@(posedge clk) disable iff (rst)
        hi_valid_o |-> (|(hi_type_o & HI_MASK)));
    assert_low_code_class_R3: assert property (@(posedge clk) disable iff (rst)
        lo_valid_o |-> !(|(lo_type_o & HI_MASK)));
endmodule

// File: tb/sim_err_aggregator.sv
`timescale 1ns/1ps
module sim_err_aggregator;
    localparam int N = 3, AW = 8, TW = 8, PW = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    src_err = '0;
    logic [N*AW-1:0] src_addr = '0;
    logic [N*TW-1:0] src_type = '0;
    logic [PW-1:0]   pc = '0;
    logic            clr_we = 1'b0;
    logic [3:0]      clr_bits = '0;
    logic            hi_pulse, lo_pulse, hi_valid, lo_valid, ovf, pc_valid;
    logic [AW-1:0]   hi_addr, lo_addr;
    logic [TW-1:0]   hi_type, lo_type;
    logic [PW-1:0]   pc_q;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    err_aggregator #(
        .N_SRC(N), .AW(AW), .TW(TW), .PW(PW), .TYPE_PRESENT(3'b011)
    ) u0 (
        .clk(clk), .rst(rst), .src_err_i(src_err), .src_addr_i(src_addr),
        .src_type_i(src_type), .pc_i(pc), .clr_we_i(clr_we), .clr_bits_i(clr_bits),
        .hi_pulse_o(hi_pulse), .lo_pulse_o(lo_pulse), .hi_valid_o(hi_valid),
        .hi_addr_o(hi_addr), .hi_type_o(hi_type), .lo_valid_o(lo_valid),
        .lo_addr_o(lo_addr), .lo_type_o(lo_type), .ovf_o(ovf),
        .pc_valid_o(pc_valid), .pc_o(pc_q)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    // Drive one cycle of stimulus; return just after the capturing edge
    task automatic drive(input logic [N-1:0] p, input logic [N*AW-1:0] a,
                         input logic [N*TW-1:0] t, input logic [PW-1:0] c,
                         input logic we, input logic [3:0] cb);
        @(negedge clk);
        src_err = p; src_addr = a; src_type = t; pc = c; clr_we = we; clr_bits = cb;
        @(negedge clk);
        src_err = '0; clr_we = 1'b0; clr_bits = '0;
    endtask

    task automatic fire1(input logic [AW-1:0] a, input logic [TW-1:0] t, input logic [PW-1:0] c);
        drive(3'b001, {16'h0, a}, {16'h0, t}, c, 1'b0, 4'h0);
    endtask

    task automatic clear(input logic [3:0] cb);
        drive('0, '0, '0, '0, 1'b1, cb);
    endtask

    initial begin
        #(200000 * 10);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [TW-1:0] tsel, et;
        logic [AW-1:0] ea;
        logic          eh;
        int            w;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        chk("R9 hi_valid", hi_valid, 0);
        chk("R9 lo_valid", lo_valid, 0);
        chk("R9 ovf", ovf, 0);
        chk("R9 pc_valid", pc_valid, 0);
        chk("R9 pulses", {hi_pulse, lo_pulse}, 0);

        // R3: every code through source 0
        for (int t = 0; t < 256; t++) begin
            clear(4'hF);
            fire1(AW'(t ^ 8'h5A), TW'(t), PW'(255 - t));
            eh = t[6];
            chk("R3 hi_pulse", hi_pulse, eh);
            chk("R3 lo_pulse", lo_pulse, !eh);
            if (eh) begin
                chk("R3 hi_addr", hi_addr, t ^ 8'h5A);
                chk("R3 hi_type", hi_type, t);
                chk("R6 pc", {pc_valid, pc_q}, {1'b1, 8'(255 - t)});
                chk("R5 lo untouched", lo_valid, 0);
            end else begin
                chk("R3 lo_addr", lo_addr, t ^ 8'h5A);
                chk("R3 lo_type", lo_type, t);
                chk("R5 hi untouched", {hi_valid, pc_valid}, 0);
            end
            @(negedge clk);
            chk("R7 pulse one cycle", {hi_pulse, lo_pulse}, 0);
        end

        // R1, R2, R4: every strobe pattern with several code sets
        for (int p = 1; p < 8; p++) begin
            for (int k = 0; k < 3; k++) begin
                logic [N*AW-1:0] a;
                logic [N*TW-1:0] ty;
                tsel = (k == 0) ? 8'h40 : (k == 1) ? 8'h13 : 8'hC1;
                for (int i = 0; i < N; i++) begin
                    a[i*AW +: AW]  = AW'(8'h10 * (i + 1) + p);
                    ty[i*TW +: TW] = tsel + TW'(i);
                end
                clear(4'hF);
                drive(N'(p), a, ty, 8'h77, 1'b0, 4'h0);
                w  = p[0] ? 0 : p[1] ? 1 : 2;
                ea = AW'(8'h10 * (w + 1) + p);
                et = (w == 2) ? 8'h40 : tsel + TW'(w);
                eh = et[6];
                chk("R2 overflow", ovf, $countones(p) > 1);
                chk("R7 class pulse", {hi_pulse, lo_pulse}, {eh, !eh});
                if (eh) chk("R1 winner hi", {hi_valid, hi_addr, hi_type}, {1'b1, ea, et});
                else    chk("R1 winner lo", {lo_valid, lo_addr, lo_type}, {1'b1, ea, et});
                if (w == 2) chk("R4 forced code", hi_type, 8'h40);
            end
        end

        // R5, R6, R8: hold and independent clears
        clear(4'hF);
        fire1(8'h21, 8'h41, 8'hA1);
        fire1(8'h22, 8'h44, 8'hA2);
        chk("R7 second hi pulse", hi_pulse, 1);
        chk("R5 hi hold", {hi_addr, hi_type}, {8'h21, 8'h41});
        chk("R6 pc hold", pc_q, 8'hA1);
        fire1(8'h23, 8'h05, 8'hA3);
        chk("R5 lo capture", {lo_valid, lo_addr, lo_type}, {1'b1, 8'h23, 8'h05});
        chk("R5 hi kept vs lo", {hi_valid, hi_addr}, {1'b1, 8'h21});
        clear(4'b0001);
        chk("R8 hi cleared", hi_valid, 0);
        chk("R8 pc lock kept", {pc_valid, pc_q}, {1'b1, 8'hA1});
        chk("R8 lo kept", lo_valid, 1);
        fire1(8'h24, 8'h60, 8'hA4);
        chk("R6 hi recapture", {hi_valid, hi_addr}, {1'b1, 8'h24});
        chk("R6 pc still first", pc_q, 8'hA1);
        clear(4'b1000);
        chk("R8 pc released", pc_valid, 0);
        chk("R8 hi kept on pc clear", hi_valid, 1);
        fire1(8'h25, 8'h40, 8'hA5);
        chk("R6 pc new snapshot", {pc_valid, pc_q}, {1'b1, 8'hA5});
        chk("R5 hi still held", hi_addr, 8'h24);
        clear(4'b0010);
        chk("R8 lo cleared", lo_valid, 0);

        // R2 and R8: overflow stickiness and its own clear
        drive(3'b011, 24'h0, 24'h0, 8'h0, 1'b0, 4'h0);
        chk("R2 ovf set", ovf, 1);
        clear(4'b1011);
        chk("R2 ovf sticky", ovf, 1);
        clear(4'b0100);
        chk("R8 ovf cleared", ovf, 0);
        drive(3'b110, 24'h0, 24'h0, 8'h0, 1'b1, 4'b0100);
        chk("R8 ovf set wins", ovf, 1);

        // R8: capture in the same cycle as its clear
        clear(4'hF);
        fire1(8'h31, 8'h40, 8'hB1);
        drive(3'b001, 24'h33, 24'h48, 8'hB3, 1'b1, 4'b1001);
        chk("R8 capture wins hi", {hi_valid, hi_addr, hi_type}, {1'b1, 8'h33, 8'h48});
        chk("R8 capture wins pc", {pc_valid, pc_q}, {1'b1, 8'hB3});

        // R9: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R9 reset clears", {hi_valid, lo_valid, ovf, pc_valid, hi_pulse, lo_pulse}, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule